// File: doc/BRIEF.md
# MD5 Block Compression Engine

This block applies the MD5 compression function to one 512-bit message block at a time and folds the result into a 128-bit running fingerprint. Padding and length encoding happen upstream, so every block handed in is already a complete, padded block. The engine takes one block, runs its 64 steps, adds the working words back into the fingerprint, and signals that the updated digest is ready. Successive blocks of one message are fed one after another without re-initialising. An initialise request resets the fingerprint to the MD5 starting constants so that a new message can begin.

Each step uses a round-dependent Boolean function, 32-bit modular additions of a per-step constant and a message word, and a left rotation. A compile-time parameter picks one of two timings. In one, a whole step finishes in a single clock. In the other, each step is split over five register stages so that less logic sits between registers, and a block takes five times as many cycles.

Top module: `md5c_core`

## Requirements
- R1: After reset, and one cycle after `init_i` is sampled high while idle, `digest_o` holds the MD5 initial words A=67452301, B=EFCDAB89, C=98BADCFE, D=10325476. Word A is at bits [31:0], B at [63:32], C at [95:64], D at [127:96]. Each word is little-endian, so digest byte k is at bits [8k+7:8k].
- R2: Message word j of a block is taken from `blk_i[32j+31:32j]`, with byte 4j+n of the block at bits [32j+8n+7:32j+8n].
- R3: For a padded block, the digest after one block from the initial state equals the standard MD5 result: the empty message gives d41d8cd98f00b204e9800998ecf8427e, and "abc" gives 900150983cd24fb0d6963f7d28e17f72, read as bytes 0 to 15.
- R4: When blocks follow one another without `init_i`, each block starts from the digest left by the previous block and updates it.
- R5: With `MULTI_CYCLE`=0, `dig_valid_o` is high for the one cycle that begins 64 clock edges after the edge that accepts the block.
- R6: With `MULTI_CYCLE`=1, that distance is 320 edges, which is five edges per step.
- R7: `blk_ready_o` is low from the cycle after acceptance until `dig_valid_o` rises. A `blk_valid_i` seen while it is low has no effect on the digest.
- R8: While a block is in progress, `init_i` is ignored. While idle, `init_i` takes priority and forces `blk_ready_o` low in that cycle.
- R9: `dig_valid_o` is a one-cycle pulse. `digest_o` changes only in the cycle where `dig_valid_o` is high or after an idle `init_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Load the initial fingerprint (idle only) |
| blk_valid_i | input | 1 | A block is offered on blk_i |
| blk_ready_o | output | 1 | Engine idle and able to take a block |
| blk_i | input | 512 | Padded message block, word j at [32j+31:32j] |
| dig_valid_o | output | 1 | One-cycle pulse: digest_o has just been updated |
| digest_o | output | 128 | Running fingerprint, A in the low word |

## Verification
A corrupted working word, a wrong constant, or a misrouted message word does not show up during the block. It appears only at the end, as a wholly different digest in the `dig_valid_o` cycle, 64 or 320 cycles after acceptance. The bench therefore compares every digest against an arithmetic model that rebuilds the constants from the sine function. A fault in the step or sub-stage counter shows as a completion pulse on the wrong cycle, which is checked against the exact edge count. A fault in the chaining register first appears on the second block of an uninitialised sequence, so several blocks are chained between initialisations.

// File: rtl/md5c_pkg.sv
package md5c_pkg;

    localparam int STEPS     = 64;
    localparam int STEP_W    = $clog2(STEPS);
    localparam int WORD_W    = 32;
    localparam int BLOCK_W   = 512;
    localparam int DIGEST_W  = 128;
    localparam int MSG_WORDS = BLOCK_W / WORD_W;
    localparam int MIDX_W    = $clog2(MSG_WORDS);

    // Starting fingerprint, word A in the low 32 bits.
    localparam logic [DIGEST_W-1:0] FP_INIT =
        128'h10325476_98badcfe_efcdab89_67452301;

    function automatic logic [WORD_W-1:0] step_const(input logic [STEP_W-1:0] s);
        case (s)
            6'd0:  step_const = 32'hd76aa478;  6'd1:  step_const = 32'he8c7b756;
            6'd2:  step_const = 32'h242070db;  6'd3:  step_const = 32'hc1bdceee;
            6'd4:  step_const = 32'hf57c0faf;  6'd5:  step_const = 32'h4787c62a;
            6'd6:  step_const = 32'ha8304613;  6'd7:  step_const = 32'hfd469501;
            6'd8:  step_const = 32'h698098d8;  6'd9:  step_const = 32'h8b44f7af;
            6'd10: step_const = 32'hffff5bb1;  6'd11: step_const = 32'h895cd7be;
            6'd12: step_const = 32'h6b901122;  6'd13: step_const = 32'hfd987193;
            6'd14: step_const = 32'ha679438e;  6'd15: step_const = 32'h49b40821;
            6'd16: step_const = 32'hf61e2562;  6'd17: step_const = 32'hc040b340;
            6'd18: step_const = 32'h265e5a51;  6'd19: step_const = 32'he9b6c7aa;
            6'd20: step_const = 32'hd62f105d;  6'd21: step_const = 32'h02441453;
            6'd22: step_const = 32'hd8a1e681;  6'd23: step_const = 32'he7d3fbc8;
            6'd24: step_const = 32'h21e1cde6;  6'd25: step_const = 32'hc33707d6;
            6'd26: step_const = 32'hf4d50d87;  6'd27: step_const = 32'h455a14ed;
            6'd28: step_const = 32'ha9e3e905;  6'd29: step_const = 32'hfcefa3f8;
            6'd30: step_const = 32'h676f02d9;  6'd31: step_const = 32'h8d2a4c8a;
            6'd32: step_const = 32'hfffa3942;  6'd33: step_const = 32'h8771f681;
            6'd34: step_const = 32'h6d9d6122;  6'd35: step_const = 32'hfde5380c;
            6'd36: step_const = 32'ha4beea44;  6'd37: step_const = 32'h4bdecfa9;
            6'd38: step_const = 32'hf6bb4b60;  6'd39: step_const = 32'hbebfbc70;
            6'd40: step_const = 32'h289b7ec6;  6'd41: step_const = 32'heaa127fa;
            6'd42: step_const = 32'hd4ef3085;  6'd43: step_const = 32'h04881d05;
            6'd44: step_const = 32'hd9d4d039;  6'd45: step_const = 32'he6db99e5;
            6'd46: step_const = 32'h1fa27cf8;  6'd47: step_const = 32'hc4ac5665;
            6'd48: step_const = 32'hf4292244;  6'd49: step_const = 32'h432aff97;
            6'd50: step_const = 32'hab9423a7;  6'd51: step_const = 32'hfc93a039;
            6'd52: step_const = 32'h655b59c3;  6'd53: step_const = 32'h8f0ccc92;
            6'd54: step_const = 32'hffeff47d;  6'd55: step_const = 32'h85845dd1;
            6'd56: step_const = 32'h6fa87e4f;  6'd57: step_const = 32'hfe2ce6e0;
            6'd58: step_const = 32'ha3014314;  6'd59: step_const = 32'h4e0811a1;
            6'd60: step_const = 32'hf7537e82;  6'd61: step_const = 32'hbd3af235;
            6'd62: step_const = 32'h2ad7d2bb;  default: step_const = 32'heb86d391;
        endcase
    endfunction

    // Rotation amount: depends on the round and the step position modulo 4.
    function automatic logic [4:0] rot_amount(input logic [STEP_W-1:0] s);
        case ({s[5:4], s[1:0]})
            4'h0: rot_amount = 5'd7;   4'h1: rot_amount = 5'd12;
            4'h2: rot_amount = 5'd17;  4'h3: rot_amount = 5'd22;
            4'h4: rot_amount = 5'd5;   4'h5: rot_amount = 5'd9;
            4'h6: rot_amount = 5'd14;  4'h7: rot_amount = 5'd20;
            4'h8: rot_amount = 5'd4;   4'h9: rot_amount = 5'd11;
            4'ha: rot_amount = 5'd16;  4'hb: rot_amount = 5'd23;
            4'hc: rot_amount = 5'd6;   4'hd: rot_amount = 5'd10;
            4'he: rot_amount = 5'd15;  default: rot_amount = 5'd21;
        endcase
    endfunction

    // Message word visited by a step, arithmetic modulo 16.
    function automatic logic [MIDX_W-1:0] word_pick(input logic [STEP_W-1:0] s);
        logic [MIDX_W-1:0] p;
        p = s[MIDX_W-1:0];
        case (s[5:4])
            2'd0:    word_pick = p;
            2'd1:    word_pick = MIDX_W'(p * 4'd5 + 4'd1);
            2'd2:    word_pick = MIDX_W'(p * 4'd3 + 4'd5);
            default: word_pick = MIDX_W'(p * 4'd7);
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] mix_fn(input logic [1:0] rnd,
                                                 input logic [WORD_W-1:0] x,
                                                 input logic [WORD_W-1:0] y,
                                                 input logic [WORD_W-1:0] z);
        case (rnd)
            2'd0:    mix_fn = (x & y) | (~x & z);
            2'd1:    mix_fn = (z & x) | (~z & y);
            2'd2:    mix_fn = x ^ y ^ z;
            default: mix_fn = y ^ (x | ~z);
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] rotl32(input logic [WORD_W-1:0] v,
                                                 input logic [4:0] n);
        logic [2*WORD_W-1:0] w;
        w = {v, v} << n;
        rotl32 = w[2*WORD_W-1:WORD_W];
    endfunction

endpackage

// File: rtl/md5c_step_ctl.sv
module md5c_step_ctl
    import md5c_pkg::*;
#(
    parameter int SUB = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic [STEP_W-1:0] step_o,
    output logic [((SUB > 1) ? $clog2(SUB) : 1)-1:0] sub_o,
    output logic              commit_o,
    output logic              last_o
);
    localparam int SUB_W = (SUB > 1) ? $clog2(SUB) : 1;

    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] step;
        logic [SUB_W-1:0]  sub;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    assign busy_o   = ctl_q.busy;
    assign step_o   = ctl_q.step;
    assign sub_o    = ctl_q.sub;
    assign commit_o = ctl_q.busy && (ctl_q.sub == SUB_W'(SUB - 1));
    assign last_o   = commit_o && (ctl_q.step == STEP_W'(STEPS - 1));

    always_comb begin
        ctl_d = ctl_q;
        if (!ctl_q.busy) begin
            if (start_i) begin
                ctl_d.busy = 1'b1;
                ctl_d.step = '0;
                ctl_d.sub  = '0;
            end
        end else if (commit_o) begin
            ctl_d.sub = '0;
            if (last_o) begin
                ctl_d.busy = 1'b0;
            end else begin
                ctl_d.step = ctl_q.step + 1'b1;
            end
        end else begin
            ctl_d.sub = ctl_q.sub + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/md5c_msg_sel.sv
module md5c_msg_sel
    import md5c_pkg::*;
(
    input  logic [BLOCK_W-1:0] blk_i,
    input  logic [STEP_W-1:0]  step_i,
    output logic [WORD_W-1:0]  word_o
);
    logic [MIDX_W-1:0] idx;

    always_comb begin
        idx    = word_pick(step_i);
        word_o = blk_i[idx*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/md5c_round_fn.sv
module md5c_round_fn
    import md5c_pkg::*;
#(
    parameter bit MULTI_CYCLE = 1'b0,
    parameter int SUB_W       = 1
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic [SUB_W-1:0]  sub_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [WORD_W-1:0] c_i,
    input  logic [WORD_W-1:0] d_i,
    input  logic [WORD_W-1:0] m_i,
    input  logic [WORD_W-1:0] tmp_i,
    output logic [WORD_W-1:0] tmp_o,
    output logic [WORD_W-1:0] b_new_o
);
    logic [WORD_W-1:0] f_val;
    logic [WORD_W-1:0] k_val;
    logic [4:0]        r_amt;

    always_comb begin
        f_val = mix_fn(step_i[5:4], b_i, c_i, d_i);
        k_val = step_const(step_i);
        r_amt = rot_amount(step_i);
    end

    generate
        if (MULTI_CYCLE) begin : g_split
            // Five sub-stages, one adder or the rotator between registers.
            always_comb begin
                tmp_o   = tmp_i;
                b_new_o = b_i + tmp_i;
                case (sub_i)
                    SUB_W'(0): tmp_o = a_i + k_val;
                    SUB_W'(1): tmp_o = tmp_i + m_i;
                    SUB_W'(2): tmp_o = tmp_i + f_val;
                    SUB_W'(3): tmp_o = rotl32(tmp_i, r_amt);
                    default:   tmp_o = tmp_i;
                endcase
            end
        end else begin : g_whole
            logic [WORD_W-1:0] sum_all;
            always_comb begin
                sum_all = a_i + f_val + k_val + m_i;
                b_new_o = b_i + rotl32(sum_all, r_amt);
                tmp_o   = (sub_i == '0) ? tmp_i : '0;
            end
        end
    endgenerate
endmodule

// File: rtl/md5c_core.sv
module md5c_core
    import md5c_pkg::*;
#(
    parameter bit MULTI_CYCLE = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_i,
    input  logic                blk_valid_i,
    output logic                blk_ready_o,
    input  logic [BLOCK_W-1:0]  blk_i,
    output logic                dig_valid_o,
    output logic [DIGEST_W-1:0] digest_o
);
    localparam int SUB   = MULTI_CYCLE ? 5 : 1;
    localparam int SUB_W = (SUB > 1) ? $clog2(SUB) : 1;

    typedef struct packed {
        logic [WORD_W-1:0]   wa;
        logic [WORD_W-1:0]   wb;
        logic [WORD_W-1:0]   wc;
        logic [WORD_W-1:0]   wd;
        logic [WORD_W-1:0]   tmp;
        logic [DIGEST_W-1:0] fp;
        logic [BLOCK_W-1:0]  msg;
        logic                done;
    } core_t;

    core_t st_d, st_q;

    logic              busy;
    logic [STEP_W-1:0] step;
    logic [SUB_W-1:0]  sub;
    logic              commit;
    logic              last;
    logic              accept;
    logic [WORD_W-1:0] m_word;
    logic [WORD_W-1:0] tmp_nxt;
    logic [WORD_W-1:0] b_new;

    assign blk_ready_o = !busy && !init_i;
    assign accept      = blk_valid_i && blk_ready_o;
    assign dig_valid_o = st_q.done;
    assign digest_o    = st_q.fp;

    md5c_step_ctl #(.SUB(SUB)) i_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (accept),
        .busy_o   (busy),
        .step_o   (step),
        .sub_o    (sub),
        .commit_o (commit),
        .last_o   (last)
    );

    md5c_msg_sel i_sel (
        .blk_i  (st_q.msg),
        .step_i (step),
        .word_o (m_word)
    );

    md5c_round_fn #(.MULTI_CYCLE(MULTI_CYCLE), .SUB_W(SUB_W)) i_rnd (
        .step_i  (step),
        .sub_i   (sub),
        .a_i     (st_q.wa),
        .b_i     (st_q.wb),
        .c_i     (st_q.wc),
        .d_i     (st_q.wd),
        .m_i     (m_word),
        .tmp_i   (st_q.tmp),
        .tmp_o   (tmp_nxt),
        .b_new_o (b_new)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!busy && init_i) begin
            st_d.fp = FP_INIT;
        end else if (accept) begin
            st_d.msg = blk_i;
            st_d.wa  = st_q.fp[31:0];
            st_d.wb  = st_q.fp[63:32];
            st_d.wc  = st_q.fp[95:64];
            st_d.wd  = st_q.fp[127:96];
            st_d.tmp = '0;
        end else if (busy) begin
            st_d.tmp = tmp_nxt;
            if (commit) begin
                st_d.wa  = st_q.wd;
                st_d.wb  = b_new;
                st_d.wc  = st_q.wb;
                st_d.wd  = st_q.wc;
                st_d.tmp = '0;
                if (last) begin
                    st_d.fp[31:0]   = st_q.fp[31:0]   + st_q.wd;
                    st_d.fp[63:32]  = st_q.fp[63:32]  + b_new;
                    st_d.fp[95:64]  = st_q.fp[95:64]  + st_q.wb;
                    st_d.fp[127:96] = st_q.fp[127:96] + st_q.wc;
                    st_d.done       = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.fp <= FP_INIT;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/md5c_core_chk.sv
module md5c_core_chk
    import md5c_pkg::*;
#(
    parameter bit MULTI_CYCLE = 1'b0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                init_i,
    input logic                blk_valid_i,
    input logic                blk_ready_o,
    input logic                dig_valid_o,
    input logic [DIGEST_W-1:0] digest_o,
    input logic                busy
);
    localparam int LAT = STEPS * (MULTI_CYCLE ? 5 : 1);

    logic [9:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (blk_valid_i && blk_ready_o) begin
            lat_q <= '0;
        end else if (busy) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    // R7
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid_i && blk_ready_o) |=> !blk_ready_o);

    // R1
    a_r1_init_loads_iv: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i && !busy) |=> (digest_o == FP_INIT));

    // R5 and R6
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        dig_valid_o |-> (lat_q == 10'(LAT)));

    // R9
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dig_valid_o |=> !dig_valid_o);

    // R9 and R8
    a_r9_digest_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_i && !busy) |=> (dig_valid_o || $stable(digest_o)));
endmodule

bind md5c_core md5c_core_chk #(.MULTI_CYCLE(MULTI_CYCLE)) i_md5c_core_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (init_i),
    .blk_valid_i (blk_valid_i),
    .blk_ready_o (blk_ready_o),
    .dig_valid_o (dig_valid_o),
    .digest_o    (digest_o),
    .busy        (busy)
);

// File: tb/test_md5c_core.sv
module test_md5c_core;
    localparam int CLK_PERIOD = 10;
    localparam logic [127:0] IV = 128'h10325476_98badcfe_efcdab89_67452301;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init = 1'b0;
    logic         valid = 1'b0;
    logic [511:0] blk = '0;
    logic         sc_ready, mc_ready, sc_dv, mc_dv;
    logic [127:0] sc_dig, mc_dig;

    int n_chk = 0;
    int n_bad = 0;
    logic [127:0] model_fp = IV;
    logic [31:0]  kc [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    md5c_core #(.MULTI_CYCLE(1'b0)) i_md5c_core (
        .clk(clk), .rst_n(rst_n), .init_i(init), .blk_valid_i(valid),
        .blk_ready_o(sc_ready), .blk_i(blk), .dig_valid_o(sc_dv), .digest_o(sc_dig));

    md5c_core #(.MULTI_CYCLE(1'b1)) i_md5c_core_mc (
        .clk(clk), .rst_n(rst_n), .init_i(init), .blk_valid_i(valid),
        .blk_ready_o(mc_ready), .blk_i(blk), .dig_valid_o(mc_dv), .digest_o(mc_dig));

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] bswap(input logic [127:0] x);
        logic [127:0] r;
        for (int k = 0; k < 16; k++) r[8*k +: 8] = x[127-8*k -: 8];
        return r;
    endfunction

    function automatic logic [31:0] rl(input logic [31:0] v, input int n);
        return (v << n) | (v >> (32 - n));
    endfunction

    // Arithmetic model: constants from the sine function, word order A..D low to high.
    function automatic logic [127:0] ref_block(input logic [127:0] fp, input logic [511:0] b);
        logic [31:0] a, bb, c, d, f, t;
        int g, s;
        int sh [4][4] = '{'{7, 12, 17, 22}, '{5, 9, 14, 20}, '{4, 11, 16, 23}, '{6, 10, 15, 21}};
        a = fp[31:0]; bb = fp[63:32]; c = fp[95:64]; d = fp[127:96];
        for (int i = 0; i < 64; i++) begin
            case (i / 16)
                0: begin f = (bb & c) | (~bb & d); g = i; end
                1: begin f = (d & bb) | (~d & c); g = (5*i + 1) % 16; end
                2: begin f = bb ^ c ^ d; g = (3*i + 5) % 16; end
                default: begin f = c ^ (bb | ~d); g = (7*i) % 16; end
            endcase
            s = sh[i/16][i%4];
            t = a + f + kc[i] + b[32*g +: 32];
            a = d; d = c; c = bb;
            bb = bb + rl(t, s);
        end
        return {fp[127:96] + d, fp[95:64] + c, fp[63:32] + bb, fp[31:0] + a};
    endfunction

    task automatic do_init();
        @(negedge clk);
        init = 1'b1;
        #1;
        check("R8 ready low during idle init (single)", {127'd0, sc_ready}, 128'd0);
        check("R8 ready low during idle init (multi)", {127'd0, mc_ready}, 128'd0);
        @(negedge clk);
        init = 1'b0;
        check("R1 init restores IV (single)", sc_dig, IV);
        check("R1 init restores IV (multi)", mc_dig, IV);
        model_fp = IV;
    endtask

    task automatic run_block(input logic [511:0] b, input bit poke_valid, input bit poke_init);
        logic [127:0] exp, sc_got, mc_got;
        int cnt, sc_lat, mc_lat, sc_pulses;
        bit fin;
        exp = ref_block(model_fp, b);
        @(negedge clk);
        check("R7 ready before block (single)", {127'd0, sc_ready}, 128'd1);
        check("R7 ready before block (multi)", {127'd0, mc_ready}, 128'd1);
        valid = 1'b1; blk = b;
        @(negedge clk);
        valid = 1'b0;
        check("R7 ready low while busy", {126'd0, sc_ready, mc_ready}, 128'd0);
        cnt = 0; sc_lat = -1; mc_lat = -1; sc_pulses = 0; fin = 0;
        sc_got = '0; mc_got = '0;
        while (!fin && cnt < 400) begin
            valid = poke_valid && (cnt == 10);
            blk   = (poke_valid && cnt == 10) ? ~b : b;
            init  = poke_init && (cnt == 20);
            @(negedge clk);
            cnt++;
            if (sc_dv) begin sc_pulses++; sc_lat = cnt; sc_got = sc_dig; end
            if (mc_dv) begin mc_lat = cnt; mc_got = mc_dig; fin = 1; end
        end
        valid = 1'b0; init = 1'b0;
        if (!fin) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R6 actual=%0d expected=320", cnt);
        end
        check("R5 single-cycle latency", 128'(sc_lat), 128'd64);
        check("R9 single pulse count", 128'(sc_pulses), 128'd1);
        check("R6 multi-cycle latency", 128'(mc_lat), 128'd320);
        check("R3 R4 digest (single)", sc_got, exp);
        check("R3 R4 digest (multi)", mc_got, exp);
        check("R9 digest held after pulse", sc_dig, exp);
        model_fp = exp;
    endtask

    initial begin : wdog
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [511:0] b;
        for (int i = 0; i < 64; i++) begin
            real v;
            v = $sin(real'(i + 1));
            if (v < 0.0) v = -v;
            kc[i] = 32'(longint'($floor(v * 4294967296.0)));
        end
        repeat (3) @(negedge clk);
        check("R1 reset digest", sc_dig, IV);
        check("R1 reset digest multi", mc_dig, IV);
        check("R9 no pulse after reset", {126'd0, sc_dv, mc_dv}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 ready after reset", {126'd0, sc_ready, mc_ready}, 128'd3);

        // R2 R3: empty message, padding byte 0x80 at byte 0, length zero.
        b = '0; b[7:0] = 8'h80;
        run_block(b, 0, 0);
        check("R3 empty-message vector", sc_dig, bswap(128'hd41d8cd98f00b204e9800998ecf8427e));
        do_init();

        // R2 R3: "abc", bit length 24 in word 14.
        b = '0; b[31:0] = 32'h80636261; b[14*32 +: 32] = 32'd24;
        run_block(b, 0, 0);
        check("R3 abc vector", mc_dig, bswap(128'h900150983cd24fb0d6963f7d28e17f72));

        // R4 chained blocks, R7 ignored valid, R8 ignored busy init.
        for (int j = 0; j < 8; j++) begin
            for (int w = 0; w < 16; w++) b[32*w +: 32] = $urandom;
            if (j == 4) do_init();
            run_block(b, j[0], j[1]);
        end
        b = '1;
        run_block(b, 1, 1);
        do_init();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule